// File: doc/BRIEF.md
# Accumulator Pointer with Modulo Stepping

This block holds the index of the working accumulator, one of four, that the arithmetic and logic datapath uses as its active operand. Next to the index it keeps a small control register. That register can make the index advance by itself after every completed operation. The index can move up or down, and it wraps inside a window of two or of four accumulators.

Software reaches both registers through a plain register port made of an address, a write strobe, write data and combinational read data. The core raises `op_done` for one cycle at the end of each arithmetic or logical operation. The block drives the active index on `acc_sel` straight from its pointer flop.

A clear command is part of the control register. It zeroes the pointer, never stays stored, and wins over any step that falls in the same cycle.

Top module: `acc_ptr_unit`

## Requirements
- R1: On reset, asynchronous and active low, `acc_sel` is 0 and both the pointer register (address 0) and the control register (address 1) read 00h.
- R2: A write to the pointer register stores write-data bits [1:0] as the index. A read of the pointer register returns the index in bits [1:0] and zeros in bits [7:2].
- R3: A write to the control register stores the step mode from bits [1:0] and the direction from bit 6. A read returns those fields in the same positions, with bit 7 and bits [5:2] always 0.
- R4: With step mode 00, `op_done` leaves the pointer unchanged.
- R5: With step mode 01, each `op_done` inverts pointer bit 0 and keeps bit 1, whatever the direction bit says.
- R6: With step mode 10 and direction bit 0, each `op_done` adds one to the pointer, and 3 wraps to 0.
- R7: With step mode 10 and direction bit 1, each `op_done` subtracts one from the pointer, and 0 wraps to 3.
- R8: Step mode 11 behaves exactly like step mode 10.
- R9: A control write with bit 7 set clears the pointer to 0 at the next clock edge, even when `op_done` is high in the same cycle. The other control fields of that write are still stored.
- R10: A pointer write in the same cycle as `op_done` takes priority: the written value is stored and no step happens.
- R11: When a control write without bit 7 coincides with `op_done`, that step uses the mode and direction held before the write. The new settings apply from the next operation on.
- R12: `acc_sel` changes only on the clock edge after a step, clear or write, and always equals the index read back from the pointer register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | ADDR_W | Register select: 0 pointer, 1 control |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| op_done | input | 1 | One-cycle pulse at the end of an operation |
| acc_sel | output | IDX_W | Active accumulator index |
| reg_rdata | output | DATA_W | Read data of the addressed register |

## Verification
The assertions rely on three things about the inputs. `op_done` arrives as a single-cycle pulse. The register port performs at most one write per cycle, so a clear and a pointer write can never coincide. `reg_addr` and `reg_we` are free of X once reset has been released. The bench drives every input on the falling edge and releases the strobes a quarter period after the rising edge, so each write and each pulse covers exactly one sampling edge. It also holds the address at a defined register whenever the strobe is low.

// File: rtl/acc_ptr_pkg.sv
package acc_ptr_pkg;

   typedef enum logic [1:0] {
      STEP_OFF      = 2'b00,
      STEP_MOD2     = 2'b01,
      STEP_MODN     = 2'b10,
      STEP_MODN_ALT = 2'b11
   } step_mode_e;

   localparam int MODE_FIELD_W = 2;

endpackage

// File: rtl/ap_ctl_reg.sv
module ap_ctl_reg
   import acc_ptr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int MODE_LSB = 0,
   parameter int DIR_BIT  = 6,
   parameter int CLR_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output step_mode_e        mode_o,
   output logic              dir_down_o,
   output logic              clr_o,
   output logic [DATA_W-1:0] rd_data
);

   step_mode_e mode_q;
   logic       dir_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= STEP_OFF;
         dir_q  <= 1'b0;
      end else if (wr_en) begin
         mode_q <= step_mode_e'(wr_data[MODE_LSB +: MODE_FIELD_W]);
         dir_q  <= wr_data[DIR_BIT];
      end
   end

   // the clear command is a pulse only; it is never stored
   assign clr_o      = wr_en && wr_data[CLR_BIT];
   assign mode_o     = mode_q;
   assign dir_down_o = dir_q;

   always_comb begin
      rd_data                            = '0;
      rd_data[MODE_LSB +: MODE_FIELD_W]  = mode_q;
      rd_data[DIR_BIT]                   = dir_q;
   end

   // R3: written fields come back on the following cycle
   assert_ctl_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mode_o == step_mode_e'($past(wr_data[MODE_LSB +: MODE_FIELD_W])))
                && (dir_down_o == $past(wr_data[DIR_BIT])));

   // R3: settings hold while no write arrives
   assert_ctl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode_o) && $stable(dir_down_o));

endmodule

// File: rtl/ap_step_unit.sv
module ap_step_unit
   import acc_ptr_pkg::*;
#(
   parameter int IDX_W = 2
) (
   input  logic [IDX_W-1:0] cur,
   input  step_mode_e       mode,
   input  logic             dir_down,
   output logic             active,
   output logic [IDX_W-1:0] nxt
);

   logic [IDX_W-1:0] wrap_val;
   logic [IDX_W-1:0] pair_val;

   // full window: natural wrap of the index width
   assign wrap_val = dir_down ? cur - 1'b1 : cur + 1'b1;

   generate
      if (IDX_W == 1) begin : g_pair_narrow
         assign pair_val = ~cur;
      end else begin : g_pair_wide
         assign pair_val = {cur[IDX_W-1:1], ~cur[0]};
      end
   endgenerate

   always_comb begin
      active = 1'b1;
      nxt    = cur;
      unique case (mode)
         STEP_OFF:                 active = 1'b0;
         STEP_MOD2:                nxt = pair_val;
         STEP_MODN, STEP_MODN_ALT: nxt = wrap_val;
         default:                  active = 1'b0;
      endcase
   end

endmodule

// File: rtl/ap_ptr_reg.sv
module ap_ptr_reg #(
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_val,
   input  logic             step_en,
   input  logic [IDX_W-1:0] step_val,
   output logic [IDX_W-1:0] ptr_q
);

   // priority: clear, then software write, then automatic step
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (clr) begin
         ptr_q <= '0;
      end else if (wr_en) begin
         ptr_q <= wr_val;
      end else if (step_en) begin
         ptr_q <= step_val;
      end
   end

   // R9: clear always lands, a step in the same cycle is dropped
   assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (ptr_q == '0));

   // R10: a software write beats a coincident step
   assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr) |=> (ptr_q == $past(wr_val)));

   // R12: with no request the index stays put
   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !wr_en && !step_en) |=> $stable(ptr_q));

endmodule

// File: rtl/acc_ptr_unit.sv
module acc_ptr_unit
   import acc_ptr_pkg::*;
#(
   parameter int                DATA_W   = 8,
   parameter int                NUM_ACC  = 4,
   parameter int                ADDR_W   = 1,
   parameter logic [ADDR_W-1:0] PTR_ADDR = '0,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 1,
   parameter int                MODE_LSB = 0,
   parameter int                DIR_BIT  = 6,
   parameter int                CLR_BIT  = 7,
   localparam int               IDX_W    = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              op_done,
   output logic [IDX_W-1:0]  acc_sel,
   output logic [DATA_W-1:0] reg_rdata
);

   // elaboration-time parameter checks
   generate
      if (NUM_ACC < 2 || (NUM_ACC & (NUM_ACC - 1)) != 0) begin : g_bad_num
         $error("NUM_ACC must be a power of two of at least 2");
      end
      if (DATA_W <= CLR_BIT || DATA_W <= DIR_BIT || DATA_W < MODE_LSB + MODE_FIELD_W) begin : g_bad_width
         $error("DATA_W too narrow for control fields");
      end
      if (IDX_W > DATA_W) begin : g_bad_idx
         $error("index wider than data port");
      end
      if (PTR_ADDR == CTL_ADDR) begin : g_bad_addr
         $error("register addresses must differ");
      end
   endgenerate

   logic              ptr_sel;
   logic              ctl_sel;
   step_mode_e        mode;
   logic              dir_down;
   logic              clr_pulse;
   logic [DATA_W-1:0] ctl_rdata;
   logic [DATA_W-1:0] ptr_rdata;
   logic              step_active;
   logic [IDX_W-1:0]  step_val;
   logic [IDX_W-1:0]  ptr_q;

   assign ptr_sel = (reg_addr == PTR_ADDR);
   assign ctl_sel = (reg_addr == CTL_ADDR);

   ap_ctl_reg #(
      .DATA_W   (DATA_W),
      .MODE_LSB (MODE_LSB),
      .DIR_BIT  (DIR_BIT),
      .CLR_BIT  (CLR_BIT)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_we && ctl_sel),
      .wr_data    (reg_wdata),
      .mode_o     (mode),
      .dir_down_o (dir_down),
      .clr_o      (clr_pulse),
      .rd_data    (ctl_rdata)
   );

   ap_step_unit #(
      .IDX_W (IDX_W)
   ) u_step (
      .cur      (ptr_q),
      .mode     (mode),
      .dir_down (dir_down),
      .active   (step_active),
      .nxt      (step_val)
   );

   ap_ptr_reg #(
      .IDX_W (IDX_W)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_pulse),
      .wr_en    (reg_we && ptr_sel),
      .wr_val   (reg_wdata[IDX_W-1:0]),
      .step_en  (op_done && step_active),
      .step_val (step_val),
      .ptr_q    (ptr_q)
   );

   always_comb begin
      ptr_rdata              = '0;
      ptr_rdata[IDX_W-1:0]   = ptr_q;
   end

   assign reg_rdata = ptr_sel ? ptr_rdata : (ctl_sel ? ctl_rdata : '0);
   assign acc_sel   = ptr_q;

   // R2: reserved pointer bits always read zero
   assert_ptr_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_sel |-> (reg_rdata >> IDX_W) == '0);

   // R3: clear bit never reads back as one
   assert_ctl_clr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_sel |-> !reg_rdata[CLR_BIT]);

   // R4: stepping off means operations leave the index alone
   assert_off_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !reg_we && mode == STEP_OFF) |=> $stable(acc_sel));

   // R5: pair mode flips bit 0 only
   assert_pair_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done && !reg_we && mode == STEP_MOD2)
      |=> (acc_sel[0] != $past(acc_sel[0]))
          && ((acc_sel >> 1) == ($past(acc_sel) >> 1)));

endmodule

// File: tb/test_acc_ptr_unit.sv
module test_acc_ptr_unit;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [0:0] reg_addr = '0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic       op_done = 1'b0;
   logic [1:0] acc_sel;
   logic [7:0] reg_rdata;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   acc_ptr_unit i_acc_ptr_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .op_done   (op_done),
      .acc_sel   (acc_sel),
      .reg_rdata (reg_rdata)
   );

   typedef struct packed {
      logic       a;
      logic       we;
      logic [7:0] d;
      logic       op;
      logic [1:0] exp;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 4'd4},   // R4 mode off
      '{1'b0, 1'b1, 8'h02, 1'b0, 2'd2, 4'd2},   // R2 write
      '{1'b0, 1'b1, 8'hFF, 1'b0, 2'd3, 4'd2},   // R2 upper bits dropped
      '{1'b1, 1'b1, 8'h01, 1'b0, 2'd3, 4'd5},   // R5 pair up
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd5},
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 4'd5},
      '{1'b1, 1'b1, 8'h41, 1'b0, 2'd3, 4'd5},   // R5 pair down
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd5},
      '{1'b1, 1'b1, 8'h02, 1'b0, 2'd2, 4'd6},   // R6 full up
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 4'd6},
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 4'd6},   // R6 wrap 3->0
      '{1'b1, 1'b1, 8'h42, 1'b0, 2'd0, 4'd7},   // R7 full down
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 4'd7},   // R7 wrap 0->3
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd7},
      '{1'b1, 1'b1, 8'h03, 1'b0, 2'd2, 4'd8},   // R8 mode 11
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd3, 4'd8},
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd0, 4'd8},
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 4'd8},
      '{1'b1, 1'b1, 8'h83, 1'b1, 2'd0, 4'd9},   // R9 clear beats step
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd1, 4'd9},   // R9 fields kept
      '{1'b0, 1'b1, 8'h02, 1'b1, 2'd2, 4'd10},  // R10 write beats step
      '{1'b1, 1'b1, 8'h42, 1'b1, 2'd3, 4'd11},  // R11 old settings used
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd11},  // R11 new settings
      '{1'b1, 1'b1, 8'h00, 1'b0, 2'd2, 4'd4},   // R4 back to off
      '{1'b0, 1'b0, 8'h00, 1'b1, 2'd2, 4'd4}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   // drive at a falling edge, release after the rising edge, return at next falling edge
   task automatic drive(input logic a, input logic we, input logic [7:0] d, input logic op);
      reg_addr  = a;
      reg_we    = we;
      reg_wdata = d;
      op_done   = op;
      @(posedge clk);
      #2;
      reg_we  = 1'b0;
      op_done = 1'b0;
      reg_addr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic a, output logic [7:0] v);
      reg_addr = a;
      #1;
      v = reg_rdata;
   endtask

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      chk("R1 acc_sel in reset", {6'b0, acc_sel}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b0, v); chk("R1 pointer after reset", v, 8'h00);
      rd(1'b1, v); chk("R1 control after reset", v, 8'h00);
      reg_addr = 1'b0;

      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].a, VECS[i].we, VECS[i].d, VECS[i].op);
         total++;
         if (acc_sel !== VECS[i].exp) begin
            bad++;
            $display("FAIL R%0d vector %0d: actual=%0d expected=%0d",
                     VECS[i].req, i, acc_sel, VECS[i].exp);
         end
      end

      // R3: readback masks clear bit and reserved bits; bit 7 also clears pointer (R9)
      drive(1'b1, 1'b1, 8'hFF, 1'b0);
      rd(1'b1, v); chk("R3 control readback", v, 8'h43);
      chk("R9 clear from FFh write", {6'b0, acc_sel}, 8'h00);

      // R2: pointer readback zero-extended
      drive(1'b0, 1'b1, 8'hFE, 1'b0);
      rd(1'b0, v); chk("R2 pointer readback", v, 8'h02);
      chk("R12 acc_sel matches readback", {6'b0, acc_sel}, v);

      // R12: output moves only at the edge (mode 11, down, ptr 2 -> 1)
      reg_addr = 1'b0;
      op_done  = 1'b1;
      #1;
      chk("R12 before edge", {6'b0, acc_sel}, 8'h02);
      @(posedge clk);
      #2;
      op_done = 1'b0;
      chk("R12 after edge", {6'b0, acc_sel}, 8'h01);
      @(negedge clk);

      // R1: reset mid-run returns everything to zero
      rst_n = 1'b0;
      #1;
      chk("R1 async reset acc_sel", {6'b0, acc_sel}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd(1'b1, v); chk("R1 control after second reset", v, 8'h00);
      reg_addr = 1'b0;
      drive(1'b0, 1'b0, 8'h00, 1'b1);
      chk("R4 off after reset", {6'b0, acc_sel}, 8'h00);

      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule